// File: doc/BRIEF.md
# Ping-Pong Register-Set DMA Channel Controller

This block moves Ethernet frames between a MAC and system memory without a descriptor ring. Each direction, receive and transmit, owns two identical register sets. Software programs one set while the engine runs from the other. When the running set finishes, the engine moves on to its partner. Receive memory is carved into fixed-stride frame slots, and a receive set counts slots rather than bytes. A transmit set carries exactly one frame.

Software writes 32-bit words on a simple write strobe bus. A word goes to one of three places: a set's base address, a set's length, or a set's command word. Control words go to a per-direction control register. Each direction reports a 16-bit status word and the remaining count of both sets. One interrupt line summarises completion and error in both directions.

Memory traffic uses valid/ready request ports, one per direction. Once a request is raised, it is held with an unchanged address until the memory side accepts it. The receive frame source is also valid/ready. A frame is taken in the same cycle that its slot write request is accepted. The ready output may depend on the source's valid, but no valid depends on a ready.

Top module: `ppdma_top`

## Requirements
- R1: After reset both channels are held: each status word reads 0x8000, no request is raised and `irq` is low.
- R2: Register word index `reg_word` = byte offset / 4. Bit 4 selects the direction (0 receive, 1 transmit). Bit 3 selects the control register. Bit 2 selects set 1, which lies 0x10 bytes above set 0. Bits 1:0 select the field: 0 base address, 1 length, 2 command.
- R3: Command 0x9800 arms a set and copies its base and length into working registers. A set is served only while its channel runs (control 0x0400) and the set is armed and active. Status bits 2 and 1 show set 1 and set 0 armed, and bit 0 shows the active set.
- R4: Each accepted receive frame causes one memory write request at the active set's current address, with length equal to the slot stride (1536 bytes). The address then advances by one stride, and the set's remaining slot count (`rx_left0`/`rx_left1`) drops by one.
- R5: When a receive set's slot count reaches zero, that set disarms, status bit 8 (done) sets and the active set toggles.
- R6: An armed transmit set raises one memory read request carrying its base and length. Once the request is accepted, the set disarms, done sets and the active set toggles.
- R7: When the finishing set's partner is already armed, the partner's first request is raised in the very next cycle.
- R8: Command 0x1100 disarms a set, so it raises no further request.
- R9: Command 0x0100 clears the done bit. `irq` is the OR of done and error over both directions and stays high until they are cleared.
- R10: A memory error pulse sets status bit 13 and blocks all requests of that direction. The ack command does not clear it. Control 0x8800 holds the channel, clears error, done and both arms, and makes set 0 active.
- R11: Control 0x1000 stops a channel (status bit 15 set) while keeping its armed sets. Control 0x0400 resumes it.
- R12: A raised request keeps its address and stays raised until accepted, while its source stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 5 | Register word index |
| reg_wdata | input | AW | Write data; commands and control use bits 15:0 |
| rx_frm_valid | input | 1 | MAC has a received frame to store |
| rx_frm_ready | output | 1 | Frame accepted this cycle |
| rxw_valid | output | 1 | Receive slot write request |
| rxw_ready | input | 1 | Memory accepts the write request |
| rxw_addr | output | AW | Slot address |
| rxw_len | output | LW | Slot size in bytes |
| rxw_err | input | 1 | Receive memory error pulse |
| txr_valid | output | 1 | Transmit frame read request |
| txr_ready | input | 1 | Memory accepts the read request |
| txr_addr | output | AW | Frame address |
| txr_len | output | LW | Frame length in bytes |
| txr_err | input | 1 | Transmit memory error pulse |
| rx_status | output | 16 | Receive status word |
| tx_status | output | 16 | Transmit status word |
| rx_left0 | output | LW | Slots remaining in receive set 0 |
| rx_left1 | output | LW | Slots remaining in receive set 1 |
| tx_left0 | output | LW | Pending length of transmit set 0 (0 once sent) |
| tx_left1 | output | LW | Pending length of transmit set 1 (0 once sent) |
| irq | output | 1 | Completion or error interrupt |

## Verification
Receive is driven with both sets armed and memory always ready. This shows whether slot addresses step by the stride, whether the chain crosses to the partner set without a gap, and whether the count stops at zero. Transmit starts with memory stalled, to tell held requests apart from dropped or re-issued ones. It then runs one set at a time, to confirm that each completion toggles the set exactly once. Halt, stop and error patterns are applied while a request is pending. These tell apart disarming, pausing with state kept, and a sticky fault that only a hold clears.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
  localparam logic [15:0] CMD_ARM  = 16'h9800;
  localparam logic [15:0] CMD_HALT = 16'h1100;
  localparam logic [15:0] CMD_ACK  = 16'h0100;
  localparam logic [15:0] CTL_HOLD = 16'h8800;
  localparam logic [15:0] CTL_RUN  = 16'h0400;
  localparam logic [15:0] CTL_OFF  = 16'h1000;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_LEN  = 2'd1,
    FLD_CMD  = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;
endpackage

// File: rtl/ppdma_chan.sv
module ppdma_chan
  import ppdma_pkg::*;
#(
  parameter bit IS_RX  = 1'b1,
  parameter int AW     = 32,
  parameter int LW     = 16,
  parameter int STRIDE = 1536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [3:0]    reg_word,
  input  logic [AW-1:0] reg_wdata,
  input  logic          src_valid,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [LW-1:0] req_len,
  input  logic          req_err,
  output logic [15:0]   status,
  output logic [LW-1:0] left0,
  output logic [LW-1:0] left1,
  output logic          flag
);
  localparam int NSET = 2;

  logic        ctl_we, set_we, sel, hold;
  fld_e        fld;
  logic [15:0] wcmd;
  logic        run_q, act_q, done_q, err_q;
  logic        go, hs, last;
  logic [NSET-1:0]         armed_v;
  logic [NSET-1:0][AW-1:0] cur_v;
  logic [NSET-1:0][LW-1:0] cnt_v;

  assign wcmd   = reg_wdata[15:0];
  assign ctl_we = reg_we && reg_word[3];
  assign set_we = reg_we && !reg_word[3];
  assign sel    = reg_word[2];
  assign fld    = fld_e'(reg_word[1:0]);
  assign hold   = ctl_we && (wcmd == CTL_HOLD);

  assign go        = run_q && !err_q && armed_v[act_q];
  assign req_valid = go && src_valid;
  assign hs        = req_valid && req_ready;
  assign last      = IS_RX ? (cnt_v[act_q] == LW'(1)) : 1'b1;
  assign req_addr  = cur_v[act_q];
  assign req_len   = IS_RX ? LW'(STRIDE) : cnt_v[act_q];

  for (genvar g = 0; g < NSET; g++) begin : g_set
    logic [AW-1:0] base_q, cur_q;
    logic [LW-1:0] len_q, cnt_q;
    logic          arm_q;
    logic          wr_me, upd_me;

    assign wr_me  = set_we && (sel == g[0]);
    assign upd_me = hs && (act_q == g[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        cur_q  <= '0;
        len_q  <= '0;
        cnt_q  <= '0;
        arm_q  <= 1'b0;
      end else if (hold) begin
        arm_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        if (wr_me) begin
          case (fld)
            FLD_BASE: base_q <= reg_wdata;
            FLD_LEN:  len_q  <= reg_wdata[LW-1:0];
            FLD_CMD: begin
              if (wcmd == CMD_ARM && len_q != '0) begin
                arm_q <= 1'b1;
                cur_q <= base_q;
                cnt_q <= len_q;
              end else if (wcmd == CMD_HALT) begin
                arm_q <= 1'b0;
              end
            end
            default: ;
          endcase
        end
        if (upd_me) begin
          cur_q <= cur_q + AW'(STRIDE);
          cnt_q <= last ? '0 : cnt_q - LW'(1);
          if (last) arm_q <= 1'b0;
        end
      end
    end

    assign armed_v[g] = arm_q;
    assign cur_v[g]   = cur_q;
    assign cnt_v[g]   = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (hold) begin
      run_q  <= 1'b0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (ctl_we && wcmd == CTL_RUN) run_q <= 1'b1;
      if (ctl_we && wcmd == CTL_OFF) run_q <= 1'b0;
      if (set_we && fld == FLD_CMD && wcmd == CMD_ACK) done_q <= 1'b0;
      if (req_err) err_q <= 1'b1;
      if (hs && last) begin
        done_q <= 1'b1;
        act_q  <= ~act_q;
      end
    end
  end

  assign status = {~run_q, 1'b0, err_q, 4'b0, done_q, 5'b0, armed_v, act_q};
  assign left0  = cnt_v[0];
  assign left1  = cnt_v[1];
  assign flag   = done_q || err_q;

  // R10: a hold leaves both sets disarmed and the fault cleared
  p_hold_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (armed_v == '0) && !status[13] && !status[8]);

  // R10: an error pulse blocks requests from the next cycle on
  p_err_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |=> !req_valid);

  // R7: an armed partner is served with no idle cycle
  p_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && last && armed_v[!act_q] && !reg_we && !req_err)
      |=> (req_valid || !src_valid));

  // R12: a stalled request keeps its address
  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !reg_we && !req_err)
      |=> (req_valid || !src_valid) && (req_addr == $past(req_addr)));

  // R4: a non-final slot costs exactly one count and keeps the set
  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !last && !reg_we)
      |=> (act_q == $past(act_q)) && (req_addr == $past(req_addr) + AW'(STRIDE)));
endmodule

// File: rtl/ppdma_top.sv
module ppdma_top
  import ppdma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LW     = 16,
  parameter int STRIDE = 1536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_word,
  input  logic [AW-1:0] reg_wdata,
  input  logic          rx_frm_valid,
  output logic          rx_frm_ready,
  output logic          rxw_valid,
  input  logic          rxw_ready,
  output logic [AW-1:0] rxw_addr,
  output logic [LW-1:0] rxw_len,
  input  logic          rxw_err,
  output logic          txr_valid,
  input  logic          txr_ready,
  output logic [AW-1:0] txr_addr,
  output logic [LW-1:0] txr_len,
  input  logic          txr_err,
  output logic [15:0]   rx_status,
  output logic [15:0]   tx_status,
  output logic [LW-1:0] rx_left0,
  output logic [LW-1:0] rx_left1,
  output logic [LW-1:0] tx_left0,
  output logic [LW-1:0] tx_left1,
  output logic          irq
);
  logic rx_we, tx_we, rx_flag, tx_flag;

  assign rx_we = reg_we && !reg_word[4];
  assign tx_we = reg_we &&  reg_word[4];

  ppdma_chan #(.IS_RX(1'b1), .AW(AW), .LW(LW), .STRIDE(STRIDE)) u_rx (
    .clk(clk), .rst_n(rst_n), .reg_we(rx_we), .reg_word(reg_word[3:0]),
    .reg_wdata(reg_wdata), .src_valid(rx_frm_valid), .req_valid(rxw_valid),
    .req_ready(rxw_ready), .req_addr(rxw_addr), .req_len(rxw_len),
    .req_err(rxw_err), .status(rx_status), .left0(rx_left0),
    .left1(rx_left1), .flag(rx_flag)
  );

  ppdma_chan #(.IS_RX(1'b0), .AW(AW), .LW(LW), .STRIDE(STRIDE)) u_tx (
    .clk(clk), .rst_n(rst_n), .reg_we(tx_we), .reg_word(reg_word[3:0]),
    .reg_wdata(reg_wdata), .src_valid(1'b1), .req_valid(txr_valid),
    .req_ready(txr_ready), .req_addr(txr_addr), .req_len(txr_len),
    .req_err(txr_err), .status(tx_status), .left0(tx_left0),
    .left1(tx_left1), .flag(tx_flag)
  );

  assign rx_frm_ready = rxw_valid && rxw_ready;
  assign irq          = rx_flag || tx_flag;

  // R9: the interrupt never fires while both directions are clean
  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_status[8] || rx_status[13] || tx_status[8] || tx_status[13]));
endmodule

// File: tb/ppdma_top_tb_top.sv
module ppdma_top_tb_top;
  localparam int AW = 32;
  localparam int LW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_word = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic rx_frm_valid = 1'b0, rxw_ready = 1'b0, rxw_err = 1'b0;
  logic txr_ready = 1'b0, txr_err = 1'b0;
  logic rx_frm_ready, rxw_valid, txr_valid, irq;
  logic [AW-1:0] rxw_addr, txr_addr;
  logic [LW-1:0] rxw_len, txr_len, rx_left0, rx_left1, tx_left0, tx_left1;
  logic [15:0] rx_status, tx_status;

  int checks = 0, errors = 0, cyc = 0;
  int rx_hs_n = 0, rx_first = 0, rx_last = 0;
  logic [AW-1:0]      rx_exp[$];
  logic [AW+LW-1:0]   tx_exp[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ppdma_top dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop and compare each accepted request
  always @(negedge clk) if (rst_n) begin
    if (rxw_valid && rxw_ready) begin
      if (rx_hs_n == 0) rx_first = cyc;
      rx_last = cyc;
      rx_hs_n++;
      if (rx_exp.size() == 0) chk("R8 unexpected rx request", rxw_addr, 32'hFFFFFFFF);
      else begin
        logic [AW-1:0] e;
        e = rx_exp.pop_front();
        chk("R4 rx slot address", rxw_addr, e);
        chk("R4 rx slot length", {16'h0, rxw_len}, 32'd1536);
        chk("R12 rx frame ready", {31'h0, rx_frm_ready}, 32'd1);
      end
    end
    if (txr_valid && txr_ready) begin
      if (tx_exp.size() == 0) chk("R8 unexpected tx request", txr_addr, 32'hFFFFFFFF);
      else begin
        logic [AW+LW-1:0] e;
        e = tx_exp.pop_front();
        chk("R6 tx address", txr_addr, e[AW+LW-1:LW]);
        chk("R6 tx length", {16'h0, txr_len}, {16'h0, e[LW-1:0]});
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [4:0] w, input logic [31:0] d);
    reg_we = 1'b1; reg_word = w; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic drain;
    for (int i = 0; i < 50 && (rx_exp.size() != 0 || tx_exp.size() != 0); i++) step(1);
    chk("R4 scoreboard drained", rx_exp.size() + tx_exp.size(), 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3); rst_n = 1'b1; step(1);
    // R1 reset
    chk("R1 rx status", rx_status, 16'h8000);
    chk("R1 tx status", tx_status, 16'h8000);
    chk("R1 irq", irq, 0);
    chk("R1 no request", {rxw_valid, txr_valid}, 0);

    // R2/R3/R4/R5/R7: receive chain over both sets
    wr(5'd0, 32'h1000); wr(5'd1, 32'd3);
    wr(5'd4, 32'h8000); wr(5'd5, 32'd2);
    wr(5'd2, 32'h9800); wr(5'd6, 32'h9800);
    chk("R3 armed while held", rx_status, 16'h8006);
    chk("R4 left0 loaded", rx_left0, 3);
    chk("R2 tx untouched", tx_status, 16'h8000);
    rx_exp.push_back(32'h1000); rx_exp.push_back(32'h1600); rx_exp.push_back(32'h1C00);
    rx_exp.push_back(32'h8000); rx_exp.push_back(32'h8600);
    rxw_ready = 1'b1; rx_frm_valid = 1'b1;
    step(2);
    chk("R3 held gives no request", rxw_valid, 0);
    rx_hs_n = 0;
    wr(5'd8, 32'h0400);
    drain();
    chk("R7 back-to-back slots", rx_last - rx_first, 4);
    chk("R5 five slots", rx_hs_n, 5);
    chk("R5 rx done, both disarmed", rx_status, 16'h0100);
    chk("R4 counts empty", {rx_left0, rx_left1}, 0);
    chk("R9 irq on done", irq, 1);
    wr(5'd2, 32'h0100);
    chk("R9 ack clears done", rx_status, 16'h0000);
    chk("R9 irq cleared", irq, 0);

    // R6/R12: transmit with stalled memory
    wr(5'd16, 32'h2000); wr(5'd17, 32'd60);
    wr(5'd20, 32'h3000); wr(5'd21, 32'd1514);
    wr(5'd18, 32'h9800); wr(5'd24, 32'h0400);
    chk("R12 tx raised", txr_valid, 1);
    step(3);
    chk("R12 tx still raised", txr_valid, 1);
    chk("R12 tx address held", txr_addr, 32'h2000);
    tx_exp.push_back({32'h2000, 16'd60});
    txr_ready = 1'b1; step(1); txr_ready = 1'b0;
    chk("R6 toggle after send", tx_status, 16'h0101);
    chk("R6 set0 length consumed", tx_left0, 0);
    tx_exp.push_back({32'h3000, 16'd1514});
    txr_ready = 1'b1;
    wr(5'd22, 32'h9800);
    step(2); txr_ready = 1'b0;
    drain();
    chk("R6 second send toggles back", tx_status, 16'h0100);
    wr(5'd18, 32'h0100);

    // R8 halt
    wr(5'd18, 32'h9800);
    chk("R8 armed raises", txr_valid, 1);
    wr(5'd18, 32'h1100);
    chk("R8 halt drops request", txr_valid, 0);
    chk("R8 status disarmed", tx_status, 16'h0000);
    txr_ready = 1'b1; step(3); txr_ready = 1'b0;

    // R11 stop keeps arm
    wr(5'd8, 32'h1000);
    wr(5'd1, 32'd2); wr(5'd2, 32'h9800);
    step(3);
    chk("R11 stopped, no request", rxw_valid, 0);
    chk("R11 status keeps arm", rx_status, 16'h8002);
    rx_exp.push_back(32'h4000 - 32'h4000 + 32'h1000);
    rx_exp.push_back(32'h1600);
    wr(5'd8, 32'h0400);
    drain();
    chk("R11 resumed and completed", rx_status, 16'h0101);
    wr(5'd2, 32'h0100);

    // R10 error
    wr(5'd18, 32'h9800);
    txr_err = 1'b1; step(1); txr_err = 1'b0;
    chk("R10 error blocks", txr_valid, 0);
    chk("R10 error status", tx_status, 16'h2002);
    chk("R10 irq on error", irq, 1);
    wr(5'd18, 32'h0100);
    chk("R10 ack keeps error", tx_status, 16'h2002);
    wr(5'd24, 32'h8800);
    chk("R10 hold clears", tx_status, 16'h8000);
    wr(5'd24, 32'h0400);
    chk("R10 released clean", tx_status, 16'h0000);
    chk("R9 irq low at end", irq, 0);

    rx_frm_valid = 1'b0; rxw_ready = 1'b0;
    step(2);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule